// File: doc/BRIEF.md
# Fuse Array Read Controller

This block gives software read access to a 512-byte one-time-programmable fuse array through a small register bus. Software takes the array out of power-down and sets the automatic-read enable. It then commits a word address with a separate latch pulse and launches a read with a start pulse. A busy flag stays high while the fetch is in flight. When the flag drops, the fetched word is already waiting in the read-data register.

The word size is fixed at build time to 1 or 4 bytes. The array is modelled inside the block as an initialised byte memory that answers after a fixed number of cycles. Bits for programming fuses, and a flag that selects encrypted contents, are kept only as storage so that software can read them back.

Top module: `fuse_read_ctrl`

## Requirements
- R1: The control register is at byte offset 0x04, the read-data register at 0x08 and the configuration register at 0x10. After reset the control register reads 0x0800_0000 (power-down bit 27 set, everything else clear), and both read-data and configuration read 0.
- R2: A write that takes control bit 11 from 0 to 1 commits the address written in bits 10:0 of that same write. Changing bits 10:0 without such a rising latch does not change the address that is read. A latch taken while a read is in flight does not disturb that read.
- R3: A write that takes control bit 25 from 0 to 1 launches a read when the same write has bit 24 (read enable) set and bit 27 (power-down) clear and no read is busy. Busy (bit 26) reads 1 immediately after that write.
- R4: Busy stays set for exactly LATENCY clock cycles. It drops on the same edge that loads the fetched word into the read-data register.
- R5: A start is ignored while powered down, while read enable is clear, while a read is busy (including the edge on which a read completes), and when bit 25 is written 1 while it is already 1.
- R6: Fuse byte i holds (i mod 256) XOR 0xA5 for i below 256 and (i mod 256) XOR 0x3C otherwise. Word N is made of bytes N*S up to N*S+S-1, where S is the word size, and byte N*S goes to bits 7:0 of the result.
- R7: A word address at or beyond 512/S returns zero and still completes normally with busy cleared.
- R8: With a word size of 1, the read-data register returns the single addressed byte in bits 7:0 with bits 31:8 zero.
- R9: Configuration bit 10 and control bits 23:16, 13 and 12 are plain storage that reads back as written. Control bits 26 and 14 and all other unlisted bits ignore writes.
- R10: The read-data register ignores bus writes and holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A read can finish on the very edge at which software writes a fresh rising start. The completion must win, so the new start is dropped because busy is still set at that edge. The bench provokes this by launching a read, clearing the start bit one cycle later, and then waiting until the next rising start lands exactly LATENCY edges after the first. It then judges that busy is clear, stays clear, and that the data register holds the first word. A second overlap is also tested: a latch pulse and a start pulse issued while a fetch is in flight. The in-flight word must be unaffected, and the new address must be used by the following read.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    // Register byte offsets decoded by software
    localparam logic [4:0] OFS_CTRL = 5'h04;
    localparam logic [4:0] OFS_DATA = 5'h08;
    localparam logic [4:0] OFS_CFG  = 5'h10;

    // Control register bit positions
    localparam int B_PD       = 27;
    localparam int B_BUSY     = 26;
    localparam int B_START    = 25;
    localparam int B_RD_EN    = 24;
    localparam int B_WDATA_LO = 16;
    localparam int B_WR_START = 13;
    localparam int B_WR_EN    = 12;
    localparam int B_LATCH    = 11;
    localparam int ADDR_W     = 11;
    localparam int B_CRYPT    = 10;

    typedef struct packed {
        logic              pd;
        logic              rd_start;
        logic              rd_en;
        logic [7:0]        wr_data;
        logic              wr_start;
        logic              wr_en;
        logic              latch;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.pd       = w[B_PD];
        c.rd_start = w[B_START];
        c.rd_en    = w[B_RD_EN];
        c.wr_data  = w[B_WDATA_LO +: 8];
        c.wr_start = w[B_WR_START];
        c.wr_en    = w[B_WR_EN];
        c.latch    = w[B_LATCH];
        c.addr     = w[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c, input logic busy);
        logic [31:0] w;
        w = '0;
        w[B_PD]              = c.pd;
        w[B_BUSY]            = busy;
        w[B_START]           = c.rd_start;
        w[B_RD_EN]           = c.rd_en;
        w[B_WDATA_LO +: 8]   = c.wr_data;
        w[B_WR_START]        = c.wr_start;
        w[B_WR_EN]           = c.wr_en;
        w[B_LATCH]           = c.latch;
        w[ADDR_W-1:0]        = c.addr;
        return w;
    endfunction

    // Initial content of fuse byte i
    function automatic logic [7:0] fuse_byte(input logic [31:0] i);
        return i[7:0] ^ (i[8] ? 8'h3C : 8'hA5);
    endfunction

endpackage

// File: rtl/fuse_rise_det.sv
module fuse_rise_det #(
    parameter int W = 2
) (
    input  logic         wr_i,
    input  logic [W-1:0] old_i,
    input  logic [W-1:0] new_i,
    output logic [W-1:0] rise_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise_o[g] = wr_i & new_i[g] & ~old_i[g];
    end
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model
    import fuse_pkg::*;
#(
    parameter int WORD_BYTES  = 4,
    parameter int ARRAY_BYTES = 512,
    parameter int LATENCY     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              active_o,
    output logic              done_o,
    output logic [31:0]       word_o
);
    localparam int NUM_WORDS = ARRAY_BYTES / WORD_BYTES;
    localparam int IDX_W     = $clog2(ARRAY_BYTES);
    localparam int CNT_W     = (LATENCY > 2) ? $clog2(LATENCY) : 1;

    logic [7:0]        fuse_mem [ARRAY_BYTES];
    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              in_range;

    always_comb begin
        for (int i = 0; i < ARRAY_BYTES; i++) begin
            fuse_mem[i] = fuse_byte(32'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
        end else if (launch_i) begin
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(LATENCY - 1);
            addr_q   <= addr_i;
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign active_o = active_q;
    assign done_o   = active_q && (cnt_q == '0);
    assign in_range = 32'(addr_q) < NUM_WORDS;

    for (genvar k = 0; k < 4; k++) begin : g_lane
        if (k < WORD_BYTES) begin : g_used
            logic [IDX_W-1:0] idx;
            assign idx = IDX_W'(32'(addr_q) * WORD_BYTES + k);
            assign word_o[k*8 +: 8] = in_range ? fuse_mem[idx] : 8'h00;
        end else begin : g_zero
            assign word_o[k*8 +: 8] = 8'h00;
        end
    end

    // R5: a new launch never lands on a fetch in flight
    assert_launch_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        launch_i |-> !active_q);

    // R2: the captured address is held for the whole fetch
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> $stable(addr_q));

endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl
    import fuse_pkg::*;
#(
    parameter int WORD_BYTES  = 4,
    parameter int ARRAY_BYTES = 512,
    parameter int LATENCY     = 4,
    parameter int BUS_AW      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    ctrl_t             ctrl_q, ctrl_w;
    logic              busy_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [31:0]       data_q;
    logic              crypt_q;
    logic              wr_ctrl, wr_cfg;
    logic [1:0]        rise;
    logic              launch;
    logic [ADDR_W-1:0] launch_addr;
    logic              arr_active, arr_done;
    logic [31:0]       arr_word;
    logic              unused_wdata;

    assign wr_ctrl = bus_we && (bus_addr == BUS_AW'(OFS_CTRL));
    assign wr_cfg  = bus_we && (bus_addr == BUS_AW'(OFS_CFG));
    assign ctrl_w  = ctrl_unpack(bus_wdata);
    assign unused_wdata = ^{bus_wdata[31:28], bus_wdata[B_BUSY], bus_wdata[15:14]};

    fuse_rise_det #(.W(2)) u_rise (
        .wr_i   (wr_ctrl),
        .old_i  ({ctrl_q.rd_start, ctrl_q.latch}),
        .new_i  ({ctrl_w.rd_start, ctrl_w.latch}),
        .rise_o (rise)
    );

    assign launch      = rise[1] && ctrl_w.rd_en && !ctrl_w.pd && !busy_q;
    assign launch_addr = rise[0] ? ctrl_w.addr : lat_addr_q;

    fuse_array_model #(
        .WORD_BYTES  (WORD_BYTES),
        .ARRAY_BYTES (ARRAY_BYTES),
        .LATENCY     (LATENCY)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .addr_i   (launch_addr),
        .active_o (arr_active),
        .done_o   (arr_done),
        .word_o   (arr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ctrl_q.pd  <= 1'b1;
            busy_q     <= 1'b0;
            lat_addr_q <= '0;
            data_q     <= '0;
            crypt_q    <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q     <= ctrl_w;
            if (rise[0]) lat_addr_q <= ctrl_w.addr;
            if (wr_cfg)  crypt_q    <= bus_wdata[B_CRYPT];
            if (arr_done) begin
                data_q <= arr_word;
                busy_q <= 1'b0;
            end else if (launch) begin
                busy_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(OFS_CTRL))      bus_rdata = ctrl_pack(ctrl_q, busy_q);
        else if (bus_addr == BUS_AW'(OFS_DATA)) bus_rdata = data_q;
        else if (bus_addr == BUS_AW'(OFS_CFG))  bus_rdata[B_CRYPT] = crypt_q;
    end

    // R4: busy only drops on a completion from the array
    assert_busy_fall_on_done_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(arr_done));

    // R3: the busy flag and the array's fetch state move together
    assert_busy_matches_array_R3: assert property (@(posedge clk) disable iff (rst)
        busy_q == arr_active);

    // R5: a read only starts when powered up and enabled
    assert_start_gated_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (!ctrl_q.pd && ctrl_q.rd_en));

    // R10: read data holds unless a fetch completes
    assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !arr_done |=> $stable(data_q));

endmodule

// File: tb/tb_fuse_read_ctrl.sv
`timescale 1ns/1ps
module tb_fuse_read_ctrl;

    localparam int LAT = 4;
    localparam logic [4:0] A_CTRL = 5'h04;
    localparam logic [4:0] A_DATA = 5'h08;
    localparam logic [4:0] A_CFG  = 5'h10;
    localparam logic [31:0] PD    = 32'h0800_0000;
    localparam logic [31:0] BUSY  = 32'h0400_0000;
    localparam logic [31:0] START = 32'h0200_0000;
    localparam logic [31:0] EN    = 32'h0100_0000;
    localparam logic [31:0] LATCH = 32'h0000_0800;

    // {word address, expected 4-byte word}
    localparam logic [42:0] VEC [6] = '{
        {11'd0,    32'hA6A7_A4A5},
        {11'd1,    32'hA2A3_A0A1},
        {11'd33,   32'h2223_2021},
        {11'd64,   32'h3F3E_3D3C},
        {11'd127,  32'hC3C2_C1C0},
        {11'd128,  32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] rdata, rdata_b;
    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    fuse_read_ctrl #(.WORD_BYTES(4), .LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata)
    );

    fuse_read_ctrl #(.WORD_BYTES(1), .LATENCY(LAT)) dut_byte (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v, output logic [31:0] vb);
        bus_addr = a;
        #1;
        v = rdata; vb = rdata_b;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v, vb;
        n = 0;
        rd(A_CTRL, v, vb);
        while (v[26] && n < 100) begin
            @(negedge clk);
            n++;
            rd(A_CTRL, v, vb);
        end
    endtask

    task automatic fetch(input logic [10:0] a, output logic first_busy, output int n);
        logic [31:0] v, vb;
        wr(A_CTRL, EN | LATCH | 32'(a));
        wr(A_CTRL, EN | 32'(a));
        wr(A_CTRL, EN | START | 32'(a));
        rd(A_CTRL, v, vb);
        first_busy = v[26];
        wait_idle(n);
        wr(A_CTRL, EN | 32'(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v, vb;
        logic fb;
        int n;

        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v, vb); chk("R1 ctrl reset", v, PD);
        rd(A_DATA, v, vb); chk("R1 data reset", v, 32'h0);
        rd(A_CFG,  v, vb); chk("R1 cfg reset",  v, 32'h0);

        // Vector table walk: R3 busy at once, R4 latency, R6/R7 word value
        for (int i = 0; i < 6; i++) begin
            fetch(VEC[i][42:32], fb, n);
            chk("R3 busy after start", 32'(fb), 32'h1);
            chk("R4 busy length", 32'(n), 32'(LAT));
            rd(A_DATA, v, vb);
            chk("R6/R7 word", v, VEC[i][31:0]);
        end

        // R8: byte-wide array
        fetch(11'd300, fb, n);
        rd(A_DATA, v, vb); chk("R8 byte 300", vb, 32'h0000_0010);
        fetch(11'd511, fb, n);
        rd(A_DATA, v, vb); chk("R8 byte 511", vb, 32'h0000_00C3);
        fetch(11'd512, fb, n);
        rd(A_DATA, v, vb); chk("R7 byte out of range", vb, 32'h0);
        chk("R7 busy clears", 32'(n), 32'(LAT));

        // R2: live address field without a latch is not used
        wr(A_CTRL, EN | LATCH | 32'd1);
        wr(A_CTRL, EN | 32'd1);
        wr(A_CTRL, EN | 32'd33);
        wr(A_CTRL, EN | START | 32'd33);
        wait_idle(n);
        rd(A_DATA, v, vb); chk("R2 latched address used", v, 32'hA2A3_A0A1);
        wr(A_CTRL, EN | 32'd33);

        // R5: powered down start ignored
        fetch(11'd0, fb, n);
        wr(A_CTRL, PD | EN | LATCH | 32'd1);
        wr(A_CTRL, PD | EN | 32'd1);
        wr(A_CTRL, PD | EN | START | 32'd1);
        rd(A_CTRL, v, vb); chk("R5 no busy when powered down", 32'(v[26]), 32'h0);
        repeat (LAT + 2) @(negedge clk);
        rd(A_DATA, v, vb); chk("R5 data kept when powered down", v, 32'hA6A7_A4A5);

        // R5: start with read enable clear ignored
        wr(A_CTRL, 32'd1);
        wr(A_CTRL, START | 32'd1);
        rd(A_CTRL, v, vb); chk("R5 no busy when disabled", 32'(v[26]), 32'h0);
        repeat (LAT + 2) @(negedge clk);
        rd(A_DATA, v, vb); chk("R5 data kept when disabled", v, 32'hA6A7_A4A5);

        // R5: holding start at 1 does not relaunch
        wr(A_CTRL, EN | 32'd1);
        wr(A_CTRL, EN | START | 32'd1);
        wait_idle(n);
        wr(A_CTRL, EN | START | 32'd1);
        rd(A_CTRL, v, vb); chk("R5 held start no relaunch", 32'(v[26]), 32'h0);

        // R5/R2: start and latch issued during a busy fetch
        wr(A_CTRL, EN | LATCH | 32'd0);
        wr(A_CTRL, EN | 32'd0);
        wr(A_CTRL, EN | START | 32'd0);
        wr(A_CTRL, EN | 32'd0);
        wr(A_CTRL, EN | START | LATCH | 32'd33);
        wr(A_CTRL, EN | 32'd33);
        rd(A_CTRL, v, vb); chk("R4 still busy before last edge", 32'(v[26]), 32'h1);
        @(negedge clk);
        rd(A_CTRL, v, vb); chk("R5 busy start ignored", 32'(v[26]), 32'h0);
        rd(A_DATA, v, vb); chk("R2 in-flight word unaffected", v, 32'hA6A7_A4A5);
        wr(A_CTRL, EN | START | 32'd33);
        wait_idle(n);
        rd(A_DATA, v, vb); chk("R2 latch during busy applied", v, 32'h2223_2021);
        wr(A_CTRL, EN | 32'd33);

        // R5/R4: new start lands on the completion edge
        wr(A_CTRL, EN | LATCH | 32'd1);
        wr(A_CTRL, EN | 32'd1);
        wr(A_CTRL, EN | START | 32'd1);
        wr(A_CTRL, EN | 32'd1);
        repeat (LAT - 2) @(negedge clk);
        wr(A_CTRL, EN | START | 32'd1);
        rd(A_CTRL, v, vb); chk("R5 start at completion ignored", 32'(v[26]), 32'h0);
        rd(A_DATA, v, vb); chk("R4 data at completion", v, 32'hA2A3_A0A1);
        repeat (2) @(negedge clk);
        rd(A_CTRL, v, vb); chk("R5 no late relaunch", 32'(v[26]), 32'h0);

        // R9: storage-only bits
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v, vb); chk("R9 cfg storage bit", v, 32'h0000_0400);
        wr(A_CFG, 32'h0);
        rd(A_CFG, v, vb); chk("R9 cfg clear", v, 32'h0);
        wr(A_CTRL, EN | BUSY | 32'h00AB_7155);
        rd(A_CTRL, v, vb); chk("R9 ctrl storage bits", v, 32'h01AB_3155);

        // R10: read-data register ignores writes
        wr(A_DATA, 32'hDEAD_BEEF);
        rd(A_DATA, v, vb); chk("R10 data not writable", v, 32'hA2A3_A0A1);

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule